// File: doc/BRIEF.md
# Adaptive Dead-Time Gate-Drive Interlock

This block holds the switching logic for one channel of a synchronous buck half-bridge. It turns a PWM command into two drive enables, one for the high-side gate and one for the low-side gate. Dead time is not a fixed count. Each enable may rise only after digital feedback says that the opposite gate has actually discharged. The gate drivers and the comparators are modelled as digital flags sampled on the clock.

Two current-limit flags change the switching sequence:

- A source-limit flag seen while the low-side is on makes the block skip the next high-side turn-on.
- A sink-limit flag seen while the low-side is on drops both gates at once, breaking the complementary pattern until the next PWM pulse.

After reset, or after the run input falls, both gates stay off until a PWM pulse arrives. This keeps a prebiased output from being discharged.

A watchdog on each gate-off handshake latches a fault and parks both gates low if the feedback never comes.

Top module: `gate_interlock`

## Requirements
- R1: `dhEn` and `dlEn` are never high in the same cycle. Once running, exactly one of them is high outside the dead-time waits.
- R2: `dhEn` rises only in the cycle after an edge at which `lsOff` was sampled 1 and `dlEn` was 0.
- R3: `dlEn` rises only in the cycle after an edge at which `hsOff` was sampled 1.
- R4: After reset, or after `runEn` was low, both enables stay 0 until a PWM pulse is seen. A pulse is a 0-to-1 change of `pwmCmd` between two consecutive clock samples; after reset the previous sample counts as 0.
- R5: If `srcLimit` is sampled 1 while `dlEn` is 1, the next PWM pulse is skipped. `dlEn` stays 1 through that pulse, and the pulse after it starts a normal turn-on.
- R6: `srcLimit` sampled while `dlEn` is 0 has no effect on the following pulse.
- R7: If `snkLimit` is sampled 1 while `dlEn` is 1, both enables are 0 from the next cycle. They stay 0 until the next PWM pulse, which starts a high-side turn-on through the `lsOff` handshake.
- R8: If a gate-off handshake waits `SENSE_TIMEOUT` edges without its feedback, `senseFault` goes to 1 and both enables stay 0 until reset, regardless of `runEn` and `pwmCmd`.
- R9: A synchronous active-high `rst` clears `dhEn`, `dlEn` and `senseFault` at the next edge and re-arms the wait for the first pulse.
- R10: When `pwmCmd` is sampled 0 while `dhEn` is 1, `dhEn` is 0 in the next cycle and the low-side handshake begins.
- R11: When `runEn` is sampled 0 (and no fault is latched), both enables are 0 in the next cycle and the block re-arms as in R4.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| runEn | input | 1 | 1 = switching allowed, 0 = park both gates and re-arm |
| pwmCmd | input | 1 | PWM command, 1 requests the high-side phase |
| hsOff | input | 1 | 1 = high-side gate sensed fully off |
| lsOff | input | 1 | 1 = low-side gate sensed fully off |
| srcLimit | input | 1 | Low-side source current-limit flag |
| snkLimit | input | 1 | Low-side sink current-limit flag |
| dhEn | output | 1 | High-side drive enable |
| dlEn | output | 1 | Low-side drive enable |
| senseFault | output | 1 | Latched gate-feedback timeout |

## Verification
All three outputs are decoded from one state register. Every result is therefore due exactly one clock after the rising edge that sampled its cause, and no output responds combinationally to an input.

The bench changes inputs on the falling edge and queues the outputs expected after the next rising edge. A monitor compares them 1 ns after that edge, so each queued item lines up with exactly one sampling edge.

The timeout case is counted edge by edge. With `SENSE_TIMEOUT` set to 4, the bench expects four quiet wait cycles and then the fault.

// File: rtl/gdi_pkg.sv
package gdi_pkg;

  // Switching phase of one half-bridge channel
  typedef enum logic [2:0] {
    ST_ARM       = 3'd0,  // parked, waiting for the first PWM pulse
    ST_HI_WAIT   = 3'd1,  // waiting for low-side gate-off feedback
    ST_HI_ON     = 3'd2,  // high-side driven
    ST_LO_WAIT   = 3'd3,  // waiting for high-side gate-off feedback
    ST_LO_ON     = 3'd4,  // low-side driven
    ST_SINK_HOLD = 3'd5,  // both off after a sink-limit event
    ST_FAULT     = 3'd6   // feedback timeout, latched
  } phase_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic lowActive;  // low-side phase is current
    logic skipTake;   // a pending skip is consumed this cycle
    logic senseWait;  // a gate-off handshake is pending
  } ctlStrobe_t;

  // Status from datapath to control
  typedef struct packed {
    logic pwmRise;  // PWM 0->1 between consecutive samples
    logic skipHit;  // the next turn-on must be skipped
    logic timeUp;   // handshake window expires at this edge
  } dpStatus_t;

endpackage

// File: rtl/gdi_datapath.sv
module gdi_datapath
  import gdi_pkg::*;
#(
  parameter int SENSE_TIMEOUT = 16
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       pwmCmd,
  input  logic       srcLimit,
  input  ctlStrobe_t strobe,
  output dpStatus_t  status
);

  localparam int TW = (SENSE_TIMEOUT < 2) ? 1 : $clog2(SENSE_TIMEOUT);
  localparam logic [TW-1:0] LAST = TW'(SENSE_TIMEOUT - 1);

  logic          pwmPrev;
  logic          skipPend;
  logic [TW-1:0] waitTimer;
  logic          timerDone;

  // previous PWM sample for edge detection
  always_ff @(posedge clk) begin
    if (rst) pwmPrev <= 1'b0;
    else     pwmPrev <= pwmCmd;
  end

  // source-limit memory, only armed while the low side conducts
  always_ff @(posedge clk) begin
    if (rst || !strobe.lowActive || strobe.skipTake) skipPend <= 1'b0;
    else if (srcLimit)                               skipPend <= 1'b1;
  end

  assign timerDone = (waitTimer == LAST);

  // handshake watchdog: counts edges spent in a wait phase
  always_ff @(posedge clk) begin
    if (rst || !strobe.senseWait) waitTimer <= '0;
    else if (!timerDone)          waitTimer <= waitTimer + 1'b1;
  end

  always_comb begin
    status.pwmRise = pwmCmd & ~pwmPrev;
    status.skipHit = strobe.lowActive & (skipPend | srcLimit);
    status.timeUp  = timerDone;
  end

endmodule

// File: rtl/gdi_control.sv
module gdi_control
  import gdi_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       runEn,
  input  logic       pwmCmd,
  input  logic       hsOff,
  input  logic       lsOff,
  input  logic       snkLimit,
  input  dpStatus_t  status,
  output ctlStrobe_t strobe,
  output logic       dhEn,
  output logic       dlEn,
  output logic       senseFault
);

  phase_e phase;
  phase_e phaseNext;
  logic   takeSkip;

  always_ff @(posedge clk) begin
    if (rst) phase <= ST_ARM;
    else     phase <= phaseNext;
  end

  always_comb begin
    phaseNext = phase;
    takeSkip  = 1'b0;
    if (phase == ST_FAULT) begin
      phaseNext = ST_FAULT;
    end else if (!runEn) begin
      phaseNext = ST_ARM;
    end else begin
      case (phase)
        ST_ARM: begin
          if (status.pwmRise) phaseNext = ST_HI_WAIT;
        end
        ST_HI_WAIT: begin
          if (lsOff)             phaseNext = ST_HI_ON;
          else if (status.timeUp) phaseNext = ST_FAULT;
        end
        ST_HI_ON: begin
          if (!pwmCmd) phaseNext = ST_LO_WAIT;
        end
        ST_LO_WAIT: begin
          if (hsOff)             phaseNext = ST_LO_ON;
          else if (status.timeUp) phaseNext = ST_FAULT;
        end
        ST_LO_ON: begin
          if (snkLimit) begin
            phaseNext = ST_SINK_HOLD;
          end else if (status.pwmRise) begin
            if (status.skipHit) takeSkip  = 1'b1;
            else                phaseNext = ST_HI_WAIT;
          end
        end
        ST_SINK_HOLD: begin
          if (status.pwmRise) phaseNext = ST_HI_WAIT;
        end
        default: phaseNext = ST_FAULT;
      endcase
    end
  end

  always_comb begin
    strobe.lowActive = (phase == ST_LO_ON);
    strobe.skipTake  = takeSkip;
    strobe.senseWait = (phase == ST_HI_WAIT) || (phase == ST_LO_WAIT);
  end

  assign dhEn       = (phase == ST_HI_ON);
  assign dlEn       = (phase == ST_LO_ON);
  assign senseFault = (phase == ST_FAULT);

endmodule

// File: rtl/gate_interlock.sv
module gate_interlock
  import gdi_pkg::*;
#(
  parameter int SENSE_TIMEOUT = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic runEn,
  input  logic pwmCmd,
  input  logic hsOff,
  input  logic lsOff,
  input  logic srcLimit,
  input  logic snkLimit,
  output logic dhEn,
  output logic dlEn,
  output logic senseFault
);

  ctlStrobe_t strobe;
  dpStatus_t  status;

  gdi_datapath #(
    .SENSE_TIMEOUT(SENSE_TIMEOUT)
  ) u_dp (
    .clk     (clk),
    .rst     (rst),
    .pwmCmd  (pwmCmd),
    .srcLimit(srcLimit),
    .strobe  (strobe),
    .status  (status)
  );

  gdi_control u_ctl (
    .clk       (clk),
    .rst       (rst),
    .runEn     (runEn),
    .pwmCmd    (pwmCmd),
    .hsOff     (hsOff),
    .lsOff     (lsOff),
    .snkLimit  (snkLimit),
    .status    (status),
    .strobe    (strobe),
    .dhEn      (dhEn),
    .dlEn      (dlEn),
    .senseFault(senseFault)
  );

endmodule

// File: rtl/gate_interlock_chk.sv
module gate_interlock_chk (
  input logic clk,
  input logic rst,
  input logic runEn,
  input logic pwmCmd,
  input logic hsOff,
  input logic lsOff,
  input logic snkLimit,
  input logic dhEn,
  input logic dlEn,
  input logic senseFault
);

  // R1
  no_overlap_chk: assert property (@(posedge clk) disable iff (rst)
    !(dhEn && dlEn));

  // R2
  hi_after_lo_off_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(dhEn) |-> ($past(lsOff) && !$past(dlEn)));

  // R3
  lo_after_hi_off_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(dlEn) |-> $past(hsOff));

  // R7
  sink_drop_chk: assert property (@(posedge clk) disable iff (rst)
    (dlEn && snkLimit && runEn) |=> (!dlEn && !dhEn));

  // R8
  fault_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    senseFault |=> senseFault);

  // R8
  fault_parks_chk: assert property (@(posedge clk) disable iff (rst)
    senseFault |-> (!dhEn && !dlEn));

  // R9
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (!dhEn && !dlEn && !senseFault));

  // R10
  hi_release_chk: assert property (@(posedge clk) disable iff (rst)
    (dhEn && !pwmCmd) |=> !dhEn);

  // R11
  run_park_chk: assert property (@(posedge clk) disable iff (rst)
    !runEn |=> (!dhEn && !dlEn));

endmodule

bind gate_interlock gate_interlock_chk u_chk (.*);

// File: tb/sim_gate_interlock.sv
module sim_gate_interlock;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic runEn = 1'b1;
  logic pwmCmd = 1'b0;
  logic hsOff = 1'b1;
  logic lsOff = 1'b1;
  logic srcLimit = 1'b0;
  logic snkLimit = 1'b0;
  logic dhEn, dlEn, senseFault;

  int checkCnt = 0;
  int failCnt = 0;
  bit done = 1'b0;

  typedef struct {
    logic  dh;
    logic  dl;
    logic  flt;
    string tag;
  } exp_t;

  exp_t expQ[$];

  always #10 clk = ~clk;

  gate_interlock #(.SENSE_TIMEOUT(4)) u0 (
    .clk(clk), .rst(rst), .runEn(runEn), .pwmCmd(pwmCmd),
    .hsOff(hsOff), .lsOff(lsOff), .srcLimit(srcLimit), .snkLimit(snkLimit),
    .dhEn(dhEn), .dlEn(dlEn), .senseFault(senseFault)
  );

  task automatic cmp(input string tag, input string name, input logic act, input logic exp);
    checkCnt++;
    if (act !== exp) begin
      failCnt++;
      $display("FAIL %s %s: actual %0b expected %0b at %0t", tag, name, act, exp, $time);
    end
  endtask

  // driver: set inputs on falling edge, queue outputs due after next rising edge
  task automatic step(input logic r, input logic p, input logic h, input logic l,
                      input logic s, input logic k, input logic u,
                      input logic eDh, input logic eDl, input logic eF, input string tag);
    exp_t e;
    @(negedge clk);
    rst = r; pwmCmd = p; hsOff = h; lsOff = l; srcLimit = s; snkLimit = k; runEn = u;
    e.dh = eDh; e.dl = eDl; e.flt = eF; e.tag = tag;
    expQ.push_back(e);
  endtask

  // monitor
  always begin
    @(posedge clk);
    #1;
    if (expQ.size() > 0) begin
      exp_t e;
      e = expQ.pop_front();
      cmp(e.tag, "dhEn", dhEn, e.dh);
      cmp(e.tag, "dlEn", dlEn, e.dl);
      cmp(e.tag, "senseFault", senseFault, e.flt);
    end
  end

  initial begin
    //    rst pwm hs ls src snk run   dh dl flt
    step(1, 0, 1, 1, 0, 0, 1,   0, 0, 0, "R9");
    step(0, 0, 1, 1, 0, 0, 1,   0, 0, 0, "R4");
    step(0, 0, 1, 1, 1, 1, 1,   0, 0, 0, "R4");
    step(0, 1, 1, 1, 0, 0, 1,   0, 0, 0, "R4");
    step(0, 1, 1, 1, 0, 0, 1,   1, 0, 0, "R2");
    step(0, 1, 0, 1, 0, 0, 1,   1, 0, 0, "R1");
    step(0, 0, 0, 1, 0, 0, 1,   0, 0, 0, "R10");
    step(0, 0, 0, 1, 0, 0, 1,   0, 0, 0, "R3");
    step(0, 0, 1, 1, 0, 0, 1,   0, 1, 0, "R3");
    step(0, 0, 1, 0, 0, 0, 1,   0, 1, 0, "R1");
    // source limit while low side on: next pulse skipped
    step(0, 0, 1, 0, 1, 0, 1,   0, 1, 0, "R5");
    step(0, 1, 1, 0, 0, 0, 1,   0, 1, 0, "R5");
    step(0, 1, 1, 0, 0, 0, 1,   0, 1, 0, "R5");
    step(0, 0, 1, 0, 0, 0, 1,   0, 1, 0, "R5");
    step(0, 1, 1, 0, 0, 0, 1,   0, 0, 0, "R5");
    step(0, 1, 1, 0, 0, 0, 1,   0, 0, 0, "R2");
    step(0, 1, 1, 1, 0, 0, 1,   1, 0, 0, "R2");
    // source limit outside low phase: ignored
    step(0, 1, 0, 1, 1, 0, 1,   1, 0, 0, "R6");
    step(0, 0, 0, 1, 1, 0, 1,   0, 0, 0, "R10");
    step(0, 0, 1, 1, 0, 0, 1,   0, 1, 0, "R3");
    step(0, 1, 1, 0, 0, 0, 1,   0, 0, 0, "R6");
    step(0, 1, 1, 1, 0, 0, 1,   1, 0, 0, "R6");
    step(0, 0, 0, 1, 0, 0, 1,   0, 0, 0, "R10");
    step(0, 0, 1, 1, 0, 0, 1,   0, 1, 0, "R3");
    // sink limit
    step(0, 0, 1, 0, 0, 1, 1,   0, 0, 0, "R7");
    step(0, 0, 1, 1, 0, 0, 1,   0, 0, 0, "R7");
    step(0, 1, 1, 1, 0, 0, 1,   0, 0, 0, "R7");
    step(0, 1, 1, 1, 0, 0, 1,   1, 0, 0, "R7");
    // run low parks and re-arms
    step(0, 1, 0, 1, 0, 0, 0,   0, 0, 0, "R11");
    step(0, 1, 1, 1, 0, 0, 1,   0, 0, 0, "R11");
    step(0, 0, 1, 1, 0, 0, 1,   0, 0, 0, "R11");
    step(0, 1, 1, 1, 0, 0, 1,   0, 0, 0, "R11");
    step(0, 1, 1, 1, 0, 0, 1,   1, 0, 0, "R11");
    // handshake timeout
    step(0, 0, 0, 1, 0, 0, 1,   0, 0, 0, "R8");
    step(0, 0, 0, 1, 0, 0, 1,   0, 0, 0, "R8");
    step(0, 0, 0, 1, 0, 0, 1,   0, 0, 0, "R8");
    step(0, 0, 0, 1, 0, 0, 1,   0, 0, 0, "R8");
    step(0, 0, 0, 1, 0, 0, 1,   0, 0, 1, "R8");
    step(0, 1, 1, 1, 0, 0, 1,   0, 0, 1, "R8");
    step(0, 1, 1, 1, 0, 0, 0,   0, 0, 1, "R8");
    // reset clears fault and re-arms
    step(1, 1, 1, 1, 0, 0, 1,   0, 0, 0, "R9");
    step(0, 1, 1, 1, 0, 0, 1,   0, 0, 0, "R4");
    step(0, 1, 1, 1, 0, 0, 1,   1, 0, 0, "R4");
    repeat (3) @(posedge clk);
    #2;
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checkCnt, failCnt);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      failCnt++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", checkCnt, failCnt);
      $finish;
    end
  end

endmodule